// File: doc/BRIEF.md
# Ripple-Carry Bit-Slice ALU

A purely combinational arithmetic-logic unit of configurable width, 32 bits by default. It is assembled from identical one-bit cells. Each cell holds an AND gate, an OR gate and a full adder, plus a four-way selector that picks the cell's output. The adders form a ripple chain: each carry-out feeds the carry-in of the next cell up.

One invert control is shared by every cell. It swaps each B bit for its complement, and the same line also drives the carry-in of bit 0. An addition with that control set therefore yields A minus B in two's complement.

The set-less-than operation gives every cell a "less" input. The sign bit from the top cell's adder is routed back into the less input of bit 0. All the other less inputs are held at zero, so the result is 0 or 1.

A zero flag reports an all-zero result. The raw carry out of the top cell is exposed unchanged. The block has no clock and no storage; a surrounding datapath registers its outputs as needed.

Top module: `ripple_alu`

## Requirements
- R1: With op_i = 2'b00 the result is A AND B', where B' is B when b_invert_i = 0 and NOT B when b_invert_i = 1.
- R2: With op_i = 2'b01 the result is A OR B', with B' chosen as in R1.
- R3: With op_i = 2'b10 and b_invert_i = 0 the result is (A + B) mod 2^WIDTH.
- R4: With op_i = 2'b10 and b_invert_i = 1 the result is (A - B) mod 2^WIDTH, because the invert line is also the bit-0 carry-in.
- R5: With op_i = 2'b11 and b_invert_i = 1, result bit 0 is 1 exactly when A is less than B as signed numbers, for operand pairs whose difference does not overflow. Result bits WIDTH-1..1 are 0.
- R6: zero_o is 1 if and only if every result bit is 0, for every operation.
- R7: For every op_i, carry_o is the carry out of the top bit of A + B' + b_invert_i. For a subtraction it is therefore 1 exactly when A >= B unsigned.
- R8: Set-less-than uses the raw adder sign and ignores overflow. With op_i = 2'b11, result bit 0 equals the top bit of A + B' + b_invert_i, including when b_invert_i = 0 and when the subtraction overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| b_invert_i | input | 1 | Complements B in every cell and sets the bit-0 carry-in |
| op_i | input | 2 | Cell output select: 00 AND, 01 OR, 10 add, 11 set-less-than |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |
| carry_o | output | 1 | Carry out of the top cell's adder |

## Verification
The assertions in the top module re-evaluate every operation each time the inputs change. They compare the assembled slices against a word-wide reference for AND, OR, add with carry, and set-less-than, and they check that the upper result bits stay clear during set-less-than. The zero flag's link to the result and the signed meaning of set-less-than need chosen operands to show anything. Such cases include sums that wrap to zero, subtractions of equal values, pairs that differ only in sign, and subtractions that overflow. Those come only from the bench's scenarios, which filter out the overflowing pairs when checking the signed comparison.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_SLT = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    binv_i,
  input  logic    cin_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    sum_o,
  output logic    cout_o
);
  logic b_sel;

  // Operand B is optionally complemented before every function in the cell.
  assign b_sel  = binv_i ? ~b_i : b_i;
  assign sum_o  = a_i ^ b_sel ^ cin_i;
  assign cout_o = (a_i & b_sel) | (a_i & cin_i) | (b_sel & cin_i);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_sel;
      OP_OR:   res_o = a_i | b_sel;
      OP_ADD:  res_o = sum_o;
      OP_SLT:  res_o = less_i;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);
  // NOR reduction over every result bit.
  assign zero_o = ~(|vec_i);
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_invert_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             carry_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum_bits;
  logic [WIDTH-1:0] res_bits;
  logic             msb_sign;

  assign op       = alu_op_e'(op_i);
  assign carry[0] = b_invert_i;
  assign msb_sign = sum_bits[MSB];

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_slice
      logic less_in;
      if (i == 0) begin : g_lsb
        assign less_in = msb_sign;
      end else begin : g_upper
        assign less_in = 1'b0;
      end
      alu_bit_slice u_slice (
        .a_i    (a_i[i]),
        .b_i    (b_i[i]),
        .binv_i (b_invert_i),
        .cin_i  (carry[i]),
        .less_i (less_in),
        .op_i   (op),
        .res_o  (res_bits[i]),
        .sum_o  (sum_bits[i]),
        .cout_o (carry[i+1])
      );
    end
  endgenerate

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .vec_i  (res_bits),
    .zero_o (zero_o)
  );

  assign result_o = res_bits;
  assign carry_o  = carry[WIDTH];

  // Word-level reference model checked against the assembled slice chain.
  logic [WIDTH-1:0] ref_b;
  logic [WIDTH:0]   ref_sum;
  assign ref_b   = b_invert_i ? ~b_i : b_i;
  assign ref_sum = {1'b0, a_i} + {1'b0, ref_b} + {{WIDTH{1'b0}}, b_invert_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, b_invert_i, op_i})) begin
      if (op_i == 2'b00)
        assert_and_R1: assert (result_o == (a_i & ref_b))
          else $error("R1 AND mismatch");
      if (op_i == 2'b01)
        assert_or_R2: assert (result_o == (a_i | ref_b))
          else $error("R2 OR mismatch");
      if (op_i == 2'b10)
        assert_add_R3: assert (result_o == ref_sum[WIDTH-1:0])
          else $error("R3/R4 add mismatch");
      assert_carry_R7: assert (carry_o == ref_sum[WIDTH])
        else $error("R7 carry mismatch");
      if (op_i == 2'b11)
        assert_slt_upper_R5: assert ($countones(result_o) <= 1 && result_o[WIDTH-1:1] == '0)
          else $error("R5 upper bits set");
      if (op_i == 2'b11)
        assert_slt_sign_R8: assert (result_o[0] == ref_sum[WIDTH-1])
          else $error("R8 sign feedback mismatch");
      if (op_i == 2'b01 && (a_i | ref_b) == '0)
        assert_zero_R6: assert (zero_o)
          else $error("R6 zero flag low on empty OR");
    end
  end
endmodule

// File: tb/sim_ripple_alu.sv
module sim_ripple_alu;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [W-1:0] a, b;
  logic         binv;
  logic [1:0]   op;
  logic [W-1:0] result;
  logic         zero, carry;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  ripple_alu #(.WIDTH(W)) u0 (
    .a_i(a), .b_i(b), .b_invert_i(binv), .op_i(op),
    .result_o(result), .zero_o(zero), .carry_o(carry)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ai, input logic [W-1:0] bi,
                       input logic bv, input logic [1:0] o);
    @(negedge clk);
    a = ai; b = bi; binv = bv; op = o;
    #1;
  endtask

  function automatic logic [W-1:0] pat(input int k, input int s);
    logic [W-1:0] v;
    v = 32'h9E3779B9 * (k + 1) ^ (32'h7F4A7C15 << (s % 7));
    return v;
  endfunction

  task automatic t_reset_state();
    apply('0, '0, 1'b0, 2'b00);
    chk("R1 idle result", result, '0);
    chk("R6 idle zero", {31'd0, zero}, 32'd1);
  endtask

  task automatic t_logic();
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] x, y;
      x = pat(k, 1); y = pat(k, 4);
      apply(x, y, 1'b0, 2'b00); chk("R1 AND", result, x & y);
      apply(x, y, 1'b1, 2'b00); chk("R1 AND inverted", result, x & ~y);
      apply(x, y, 1'b0, 2'b01); chk("R2 OR", result, x | y);
      apply(x, y, 1'b1, 2'b01); chk("R2 OR inverted", result, x | ~y);
    end
  endtask

  task automatic t_add();
    logic [W:0] s;
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] x, y;
      x = pat(k, 2); y = pat(k, 5);
      s = {1'b0, x} + {1'b0, y};
      apply(x, y, 1'b0, 2'b10);
      chk("R3 sum", result, s[W-1:0]);
      chk("R7 add carry", {31'd0, carry}, {31'd0, s[W]});
    end
    apply(32'hFFFF_FFFF, 32'd1, 1'b0, 2'b10);
    chk("R3 wrap", result, '0);
    chk("R7 wrap carry", {31'd0, carry}, 32'd1);
    chk("R6 wrap zero", {31'd0, zero}, 32'd1);
  endtask

  task automatic t_sub();
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] x, y;
      x = pat(k, 3); y = pat(k, 6);
      apply(x, y, 1'b1, 2'b10);
      chk("R4 diff", result, x - y);
      chk("R7 borrow carry", {31'd0, carry}, {31'd0, x >= y});
      chk("R6 nonzero diff", {31'd0, zero}, {31'd0, x == y});
    end
    apply(32'h1234_5678, 32'h1234_5678, 1'b1, 2'b10);
    chk("R4 equal diff", result, '0);
    chk("R6 equal zero", {31'd0, zero}, 32'd1);
    chk("R7 equal carry", {31'd0, carry}, 32'd1);
  endtask

  task automatic t_slt();
    logic [W-1:0] xs [8] = '{32'd5, 32'hFFFF_FFFF, 32'd7, 32'h8000_0001, 32'd0, 32'h7FFF_FFF0, pat(3,1), pat(9,2)};
    logic [W-1:0] ys [8] = '{32'd9, 32'd0, 32'd7, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0010, pat(5,3), pat(2,4)};
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] d;
      logic ovf;
      d = xs[k] - ys[k];
      ovf = (xs[k][W-1] != ys[k][W-1]) && (d[W-1] != xs[k][W-1]);
      apply(xs[k], ys[k], 1'b1, 2'b11);
      if (!ovf)
        chk("R5 signed less", result, {31'd0, $signed(xs[k]) < $signed(ys[k])});
      chk("R5 upper clear", result & 32'hFFFF_FFFE, '0);
      chk("R6 slt zero", {31'd0, zero}, {31'd0, result == '0});
    end
  endtask

  task automatic t_slt_raw();
    logic [W:0] s;
    // Overflowing subtraction: 0x80000000 - 1 gives raw sign 0.
    apply(32'h8000_0000, 32'd1, 1'b1, 2'b11);
    chk("R8 overflow raw sign", result, 32'd0);
    // Without invert the sign of A + B is reported.
    s = {1'b0, 32'h4000_0000} + {1'b0, 32'h4000_0000};
    apply(32'h4000_0000, 32'h4000_0000, 1'b0, 2'b11);
    chk("R8 add sign", result, {31'd0, s[W-1]});
    chk("R7 slt carry", {31'd0, carry}, {31'd0, s[W]});
    apply(32'hFFFF_FFFF, 32'd1, 1'b0, 2'b01);
    chk("R7 carry during OR", {31'd0, carry}, 32'd1);
  endtask

  initial begin
    a = '0; b = '0; binv = 1'b0; op = 2'b00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_slt_raw();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule